// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked request port and an external static RAM that has no clock. A requester offers address, write data, per-byte lane enables and a write flag with a valid/ready handshake. The controller then drives the memory's two chip selects, its output-enable and write strobes, its active-low lane selects and its address. It also drives the data bus, with a separate enable for the bus driver. Read data comes back on a response port, flagged by a single-cycle valid pulse. The memory is always used in word mode.

Every analog timing minimum is met by counting clock cycles. Each count is a parameter worked out from the clock period and a nanosecond figure, rounded up. A read holds the strobes for the longest of the cycle-time, address-access and output-enable-access counts. A write pulse lasts for the longest of the pulse-width, write-cycle and data-setup counts. After a read there is a bus-release count that must pass before the controller drives the data bus again.

While no transfer is in flight, the memory is parked in standby, with the first chip select high and the second low.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and whenever no transfer is in flight, the outputs are in standby: `sram_ce1_n_o`=1, `sram_ce2_o`=0, `sram_oe_n_o`=1, `sram_we_n_o`=1, `sram_dq_oe_o`=0, all `sram_be_n_o` bits 1, and `rsp_valid_o`=0.
- R2: `req_ready_o` is high only when idle. A request is taken on the clock edge where `req_valid_i` and `req_ready_o` are both high. From that edge, `req_ready_o` stays low until the transfer's strobes have returned to standby.
- R3: A read holds the chip selects active, `sram_oe_n_o` low and `sram_we_n_o` high for exactly RD_CYC cycles, beginning the cycle after acceptance. RD_CYC = max(ceil(T_RC/period), ceil(T_ACC/period), ceil(T_OE/period)).
- R4: `sram_dq_i` is sampled on the clock edge that ends the read strobes. It is presented on `rsp_rdata_o` with `rsp_valid_o` high for exactly one cycle, namely the first cycle after the strobes drop.
- R5: A write holds `sram_we_n_o` low for exactly WP_CYC cycles, where WP_CYC = max(ceil(T_WP/period), ceil(T_WC/period), ceil(T_DS/period)). During that time `sram_oe_n_o` stays high. `sram_dq_oe_o` is high exactly while `sram_we_n_o` is low, and `sram_dq_o` then carries the request's write data.
- R6: Address and lane selects are loaded on the acceptance edge. They do not change on any clock edge while `sram_we_n_o` stays low.
- R7: `sram_dq_oe_o` rises no sooner than TURN_CYC = ceil(T_BUS_REL/period) cycles after `sram_oe_n_o` rises. If a write is accepted earlier than that, it holds the chip selects, address and lane selects with `sram_we_n_o` high until that point, and only then starts its pulse.
- R8: Bit i of `req_be_i`, when high, enables byte lane i (data bits 8i+7..8i). This drives `sram_be_n_o` bit i low for the whole transfer. A lane left disabled in a write keeps its old memory contents.
- R9: A request held valid is taken in the very cycle that `req_ready_o` returns, which is also the cycle in which a read's `rsp_valid_o` is high. Requests can therefore run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Lane enables, active high |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | DATA_W | Read data |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_be_n_o | output | DATA_W/8 | Lane selects, active low |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data driven toward memory |
| sram_dq_oe_o | output | 1 | Enable for data bus driver |
| sram_dq_i | input | DATA_W | Data returned from memory |

## Verification
The bench runs the slower timing set, which gives three-cycle reads and writes and a two-cycle bus release. With those counts it can reach the path where a write waits after a read. A controller that skipped the wait would drive the bus while the memory was still releasing it, and the first cycle of that write would show its data enable high. The bench also aims at partial-lane writes followed by full reads: a controller that dropped lane selects would overwrite the untouched byte, and that corruption shows up in the returned data. Requests are chained with valid held high. A controller that added a dead cycle, or fired its response a cycle early or late, falls out of step with the cycle model on the ready and valid pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE
  } sram_st_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_guard.sv
// Counts bus-release time after the read strobe drops.
module sram_bus_guard #(
  parameter int TURN_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  output logic bus_ok_o
);

  generate
    if (TURN_CYC <= 1) begin : g_none
      // The clock edge that starts the pulse already supplies one full cycle
      assign bus_ok_o = 1'b1;
    end else begin : g_cnt
      localparam int TW = $clog2(TURN_CYC + 1);
      logic [TW-1:0] ta_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          ta_q <= '0;
        else if (release_i)   ta_q <= TW'(TURN_CYC);
        else if (ta_q != '0)  ta_q <= ta_q - 1'b1;
      end

      assign bus_ok_o = (ta_q <= TW'(1));
    end
  endgenerate

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 40,
  parameter int T_ACC_NS      = 40,
  parameter int T_OE_NS       = 25,
  parameter int T_WP_NS       = 30,
  parameter int T_WC_NS       = 40,
  parameter int T_DS_NS       = 20,
  parameter int T_BUS_REL_NS  = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                sram_ce1_n_o,
  output logic                sram_ce2_o,
  output logic                sram_oe_n_o,
  output logic                sram_we_n_o,
  output logic [DATA_W/8-1:0] sram_be_n_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic [DATA_W-1:0]   sram_dq_o,
  output logic                sram_dq_oe_o,
  input  logic [DATA_W-1:0]   sram_dq_i
);

  localparam int LANES    = DATA_W / 8;
  localparam int RD_RAW   = max3(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int WP_RAW   = max3(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_WC_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
  localparam int RD_CYC   = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_CYC   = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int TURN_CYC = ns_to_cyc(T_BUS_REL_NS, CLK_PERIOD_NS);
  localparam int PH_MAX   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int PH_W     = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  sram_st_e          st_q, st_d;
  logic              ph_load, ph_done, rd_end, bus_ok, accept;
  logic [PH_W-1:0]   ph_val;

  logic              ce1_n_q, ce2_q, oe_n_q, we_n_q, dq_oe_q, rsp_valid_q;
  logic [LANES-1:0]  be_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  sram_phase_cnt #(.CNT_W(PH_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ph_load),
    .load_val_i (ph_val),
    .done_o     (ph_done)
  );

  sram_bus_guard #(.TURN_CYC(TURN_CYC)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (rd_end),
    .bus_ok_o  (bus_ok)
  );

  always_comb begin
    st_d    = st_q;
    ph_load = 1'b0;
    ph_val  = '0;
    rd_end  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_we_i) begin
            st_d    = ST_READ;
            ph_load = 1'b1;
            ph_val  = PH_W'(RD_CYC - 1);
          end else if (bus_ok) begin
            st_d    = ST_WRITE;
            ph_load = 1'b1;
            ph_val  = PH_W'(WP_CYC - 1);
          end else begin
            st_d    = ST_WAIT;
          end
        end
      end
      ST_READ: begin
        if (ph_done) begin
          st_d   = ST_IDLE;
          rd_end = 1'b1;
        end
      end
      ST_WAIT: begin
        if (bus_ok) begin
          st_d    = ST_WRITE;
          ph_load = 1'b1;
          ph_val  = PH_W'(WP_CYC - 1);
        end
      end
      ST_WRITE: begin
        if (ph_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ce1_n_q     <= 1'b1;
      ce2_q       <= 1'b0;
      oe_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      be_n_q      <= '1;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      st_q        <= st_d;
      ce1_n_q     <= (st_d == ST_IDLE);
      ce2_q       <= (st_d != ST_IDLE);
      oe_n_q      <= (st_d != ST_READ);
      we_n_q      <= (st_d != ST_WRITE);
      dq_oe_q     <= (st_d == ST_WRITE);
      rsp_valid_q <= rd_end;
      if (rd_end) rdata_q <= sram_dq_i;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_n_q  <= ~req_be_i;
      end else if (st_d == ST_IDLE) begin
        be_n_q  <= '1;
      end
    end
  end

  assign sram_ce1_n_o = ce1_n_q;
  assign sram_ce2_o   = ce2_q;
  assign sram_oe_n_o  = oe_n_q;
  assign sram_we_n_o  = we_n_q;
  assign sram_dq_oe_o = dq_oe_q;
  assign sram_be_n_o  = be_n_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;

  p_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (sram_ce1_n_o && !sram_ce2_o && sram_oe_n_o &&
                           sram_we_n_o && !sram_dq_oe_o && (&sram_be_n_o)));

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_rsp_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_rsp_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(!sram_oe_n_o));

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_n_o && sram_dq_oe_o));

  p_drive_in_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o == !sram_we_n_o);

  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |->
      ($stable(sram_addr_o) && $stable(sram_be_n_o)));

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> $past(bus_ok));

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int AW = 19, DW = 16, NL = DW / 8, PER = 20;
  localparam int G_RC = 55, G_ACC = 55, G_OE = 30, G_WP = 40, G_WC = 55, G_DS = 25, G_REL = 25;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  int rd_n, wp_n, turn_n;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NL-1:0] req_be = '0;
  logic req_ready, rsp_valid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [NL-1:0] be_n;
  logic [AW-1:0] addr;

  always #(PER/2) clk = ~clk;

  sram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER),
    .T_RC_NS(G_RC), .T_ACC_NS(G_ACC), .T_OE_NS(G_OE), .T_WP_NS(G_WP),
    .T_WC_NS(G_WC), .T_DS_NS(G_DS), .T_BUS_REL_NS(G_REL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
    .sram_be_n_o(be_n), .sram_addr_o(addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // memory behind the pins
  logic [DW-1:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always_comb begin
    dq_i = '0;
    if (!ce1_n && ce2 && !oe_n && we_n)
      for (int l = 0; l < NL; l++)
        if (!be_n[l]) dq_i[l*8 +: 8] = mem[addr[3:0]][l*8 +: 8];
  end

  always @(negedge clk)
    if (!ce1_n && ce2 && !we_n && dq_oe)
      for (int l = 0; l < NL; l++)
        if (!be_n[l]) mem[addr[3:0]][l*8 +: 8] <= dq_o[l*8 +: 8];

  // cycle model: mode 0 idle, 1 read, 2 wait, 3 write pulse
  int m_mode, m_left, m_since;
  logic m_rv;
  logic [DW-1:0] m_rd, m_wd;
  logic [AW-1:0] m_addr;
  logic [NL-1:0] m_be;
  logic [DW-1:0] shadow [16];
  initial for (int i = 0; i < 16; i++) shadow[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_since = 1000; m_rv = 1'b0; m_left = 0;
    end else begin
      m_rv = 1'b0;
      if (m_since < 1000) m_since++;
      case (m_mode)
        0: if (req_valid) begin
          m_addr = req_addr; m_be = req_be; m_wd = req_wdata;
          if (req_we) begin
            for (int l = 0; l < NL; l++)
              if (req_be[l]) shadow[req_addr[3:0]][l*8 +: 8] = req_wdata[l*8 +: 8];
            if (m_since >= turn_n) begin m_mode = 3; m_left = wp_n; end
            else m_mode = 2;
          end else begin
            m_mode = 1; m_left = rd_n;
          end
        end
        1: begin
          m_left--;
          if (m_left == 0) begin
            m_mode = 0; m_rv = 1'b1; m_since = 0;
            m_rd = '0;
            for (int l = 0; l < NL; l++)
              if (m_be[l]) m_rd[l*8 +: 8] = shadow[m_addr[3:0]][l*8 +: 8];
          end
        end
        2: if (m_since >= turn_n) begin m_mode = 3; m_left = wp_n; end
        default: begin
          m_left--;
          if (m_left == 0) m_mode = 0;
        end
      endcase
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  logic run_chk = 1'b0;
  int gap;
  logic oe_prev, dq_prev, we_prev;
  logic [AW-1:0] addr_prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      check({ce1_n, ce2, oe_n, we_n, dq_oe, rsp_valid} == 6'b101100 && &be_n,
            "R1 reset", {ce1_n, ce2, oe_n, we_n, dq_oe, rsp_valid}, 6'b101100);
      gap = 1000; oe_prev = 1'b1; dq_prev = 1'b0; we_prev = 1'b1;
    end else if (run_chk) begin
      logic [4:0] e_s;
      e_s = {m_mode == 0, m_mode != 0, m_mode != 1, m_mode != 3, m_mode == 3};
      case (m_mode)
        0: check({ce1_n, ce2, oe_n, we_n, dq_oe} == e_s, "R1 standby", {ce1_n, ce2, oe_n, we_n, dq_oe}, e_s);
        1: check({ce1_n, ce2, oe_n, we_n, dq_oe} == e_s, "R3 read strobes", {ce1_n, ce2, oe_n, we_n, dq_oe}, e_s);
        2: check({ce1_n, ce2, oe_n, we_n, dq_oe} == e_s, "R7 wait strobes", {ce1_n, ce2, oe_n, we_n, dq_oe}, e_s);
        default: check({ce1_n, ce2, oe_n, we_n, dq_oe} == e_s, "R5 write strobes", {ce1_n, ce2, oe_n, we_n, dq_oe}, e_s);
      endcase
      if (m_rv) check(req_ready == 1'b1, "R9 ready with response", req_ready, 1);
      else check(req_ready == (m_mode == 0), "R2 ready", req_ready, m_mode == 0);
      check(be_n == ((m_mode == 0) ? {NL{1'b1}} : ~m_be), "R8 lane selects", be_n,
            (m_mode == 0) ? {NL{1'b1}} : ~m_be);
      if (m_mode != 0) check(addr == m_addr, "R6 address", addr, m_addr);
      if (m_mode == 3) check(dq_o == m_wd, "R5 write data", dq_o, m_wd);
      check(rsp_valid == m_rv, "R4 response valid", rsp_valid, m_rv);
      if (m_rv) check(rsp_rdata == m_rd, "R4 read data", rsp_rdata, m_rd);
      if (!we_n && !we_prev) check(addr == addr_prev, "R6 address held in pulse", addr, addr_prev);
      if (oe_n && !oe_prev) gap = 0;
      else if (gap < 1000) gap++;
      if (dq_oe && !dq_prev) check(gap >= turn_n, "R7 bus release gap", gap, turn_n);
      oe_prev = oe_n; dq_prev = dq_oe; we_prev = we_n; addr_prev = addr;
    end
  end

  task automatic issue(input bit we, input int a, input logic [DW-1:0] d,
                       input logic [NL-1:0] be);
    bit was_rdy;
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d; req_be = be;
    forever begin
      was_rdy = req_ready;
      @(negedge clk);
      if (was_rdy) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rd_n   = mx(cdiv(G_RC), cdiv(G_ACC), cdiv(G_OE));
    wp_n   = mx(cdiv(G_WP), cdiv(G_WC), cdiv(G_DS));
    turn_n = cdiv(G_REL);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; run_chk = 1'b1;
    idle(2);
    issue(1, 1, 16'hA5C3, 2'b11);           // R5 full write
    idle(1);
    issue(0, 1, 16'h0, 2'b11);              // R3 R4 read back
    idle(2);
    issue(1, 2, 16'h1234, 2'b11);
    issue(1, 2, 16'hFF00, 2'b01);           // R8 low lane only, back to back
    issue(0, 2, 16'h0, 2'b11);              // expect 1200
    issue(0, 2, 16'h0, 2'b10);              // R8 read upper lane only
    issue(1, 3, 16'hBEEF, 2'b11);           // R7 write right after read
    issue(0, 3, 16'h0, 2'b11);
    issue(0, 5, 16'h0, 2'b11);              // unwritten word
    issue(1, 5, 16'h00C4, 2'b10);           // R8 high lane only
    idle(1);
    issue(0, 5, 16'h0, 2'b11);              // expect 0000
    idle(1);
    issue(1, 4, 16'h5A5A, 2'b11);
    issue(0, 4, 16'h0, 2'b01);
    idle(6);
    summary();
  end

endmodule